// File: doc/BRIEF.md
# Ethernet receive FIFO admission controller

This block sits between a MAC receive byte stream and a DMA drain port. It holds a byte FIFO and a queue of frame records, and decides for every incoming frame whether the frame is stored whole, cut short, discarded or flushed. Bytes of a frame become visible to the drain side only when the frame is committed. A committed frame is either a frame that finished normally or a frame that was cut short when the FIFO filled up.

The DMA side pops bytes one at a time. It pops the head frame record once the frame has been transferred, and it returns a write-back-complete strobe for the record it popped last. The block sets sticky status flags for each error class: frame error, receive abort, byte-space overflow, frame-count overflow and cut-off. It raises a maskable interrupt from those flags. It also counts frames that were discarded whole.

All admission decisions are made on the first byte of a frame. A frame refused at that point is ignored until its last byte.

Top module: `eth_rx_admit`

## Requirements
- R1: Bytes of a committed frame leave on `byte_data_o` in arrival order, one per `byte_pop_i` cycle. `byte_avail_o` counts committed, undrained bytes only.
- R2: Each committed frame adds one record carrying its stored length, error bit and truncated bit. At most `MAX_FRAMES` (24) records are held, and `rec_pop_i` removes the head record.
- R3: A frame whose last byte carries `rx_err_i`, and whose byte count is below `RUNT_LEN` (32), is flushed. No bytes, no record and no flag remain. Pad bytes present on the stream count toward the length, so a 31-byte frame is flushed and a 32-byte frame is kept.
- R4: A kept error frame is delivered with its error bit set. Flag bit 0 (frame error) and flag bit 1 (receive abort) are set only when `wb_done_i` arrives for that frame's popped record.
- R5: A frame that starts while the FIFO has no free byte, or while the resume hold is active, is discarded whole. This sets flag bit 2 (byte overflow) and adds one to the missed-frame count. The byte-space check takes priority over the frame-count check.
- R6: A frame that starts while 24 records are pending is discarded whole. This sets flag bit 3 (count overflow) and adds one to the missed-frame count. A frame that starts after one record has been popped is accepted.
- R7: An accepted frame that meets a full FIFO is committed with the bytes already stored and a truncated record, and its remaining bytes are dropped. The missed-frame count is unchanged. Flag bit 4 (cut-off) is set when that record's write-back completes.
- R8: After a byte overflow or a cut-off, new frames are refused until at least `RESUME_FREE` (32) bytes are free when a frame starts.
- R9: A frame refused at its start stays discarded up to its last byte, even if space frees while it is arriving.
- R10: Flags are sticky. Writing 1 to a bit of `flag_clr_i` clears that bit, and a set in the same cycle wins over the clear.
- R11: `irq_o` is high exactly when some flag is set and its bit in `irq_en_i` is high.
- R12: The missed-frame counter saturates at all ones. `miss_clr_i` zeroes it and wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Last byte of frame |
| rx_err_i | input | 1 | Frame ended in error (qualified by last) |
| byte_pop_i | input | 1 | Drain one committed byte |
| byte_data_o | output | 8 | Head committed byte |
| byte_avail_o | output | AW+1 | Committed bytes waiting |
| rec_pop_i | input | 1 | Pop head frame record |
| rec_valid_o | output | 1 | A record is pending |
| rec_len_o | output | AW+1 | Head record stored length |
| rec_err_o | output | 1 | Head record error bit |
| rec_trunc_o | output | 1 | Head record truncated bit |
| wb_done_i | input | 1 | Write-back complete for last popped record |
| flag_clr_i | input | 5 | Write-one-to-clear flag strobes |
| irq_en_i | input | 5 | Per-flag interrupt enables |
| flags_o | output | 5 | Sticky status flags |
| irq_o | output | 1 | Interrupt request |
| miss_clr_i | input | 1 | Clear missed-frame counter |
| miss_cnt_o | output | MISS_W | Missed-frame counter |

## Verification
The assertions check several rules on every cycle. The FIFO is never written when it has no free byte, and the record queue never grows past its limit or takes a push while full. A refused frame holds its discard state until its last byte. Flags stay set unless cleared, a saturated counter stays saturated, and error flags follow a write-back of an error record. The bench scenarios cover the behaviours that depend on sequence:
- the runt boundary at 31 and 32 bytes;
- cut-off delivery leaving the miss count unchanged;
- the resume hold that refuses a frame while fewer than 32 bytes are free;
- frame-count recovery after one pop;
- interrupt masking.

// File: rtl/rxadm_pkg.sv
package rxadm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TAKE, ST_DROP} adm_state_e;
  localparam int NFLAGS     = 5;
  localparam int FL_FRERR   = 0;
  localparam int FL_ABORT   = 1;
  localparam int FL_BYTEOVF = 2;
  localparam int FL_CNTOVF  = 3;
  localparam int FL_CUTOFF  = 4;
endpackage

// File: rtl/rxadm_byte_fifo.sv
module rxadm_byte_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          commit_i,
  input  logic          flush_i,
  input  logic          rd_en_i,
  output logic [7:0]    rd_data_o,
  output logic [PW-1:0] free_o,
  output logic [PW-1:0] avail_o
);
  logic [PW-1:0] wr_ptr_q, cmt_ptr_q, rd_ptr_q, wr_n, used;
  logic [7:0]    mem_q [DEPTH];

  assign wr_n    = wr_ptr_q + PW'(wr_en_i);
  assign used    = wr_ptr_q - rd_ptr_q;
  assign free_o  = PW'(DEPTH) - used;
  assign avail_o = cmt_ptr_q - rd_ptr_q;
  assign rd_data_o = mem_q[rd_ptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      cmt_ptr_q <= '0;
      rd_ptr_q  <= '0;
    end else begin
      wr_ptr_q <= flush_i ? cmt_ptr_q : wr_n;
      if (commit_i) cmt_ptr_q <= wr_n;
      if (rd_en_i && avail_o != '0) rd_ptr_q <= rd_ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q[AW-1:0]] <= wr_data_i;
  end

  AST_NO_WRITE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> free_o != '0); // R7
  AST_AVAIL_LE_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o <= used); // R1
  AST_FLUSH_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !wr_en_i && !commit_i); // R3
endmodule

// File: rtl/rxadm_rec_queue.sv
module rxadm_rec_queue #(
  parameter int DEPTH = 24,
  parameter int LW    = 7,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [LW-1:0] push_len_i,
  input  logic          push_err_i,
  input  logic          push_trunc_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [LW-1:0] len_o,
  output logic          err_o,
  output logic          trunc_o,
  output logic [CW-1:0] cnt_o
);
  logic [LW-1:0] len_mem [DEPTH];
  logic          err_mem [DEPTH];
  logic          trc_mem [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic          pop_eff;

  assign valid_o = cnt_q != '0;
  assign pop_eff = pop_i && valid_o;
  assign cnt_o   = cnt_q;
  assign len_o   = len_mem[head_q];
  assign err_o   = err_mem[head_q];
  assign trunc_o = trc_mem[head_q];

  function automatic logic [IW-1:0] wrap_inc(logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i)  tail_q <= wrap_inc(tail_q);
      if (pop_eff) head_q <= wrap_inc(head_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_eff);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      len_mem[tail_q] <= push_len_i;
      err_mem[tail_q] <= push_err_i;
      trc_mem[tail_q] <= push_trunc_i;
    end
  end

  AST_REC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R2
  AST_REC_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q != CW'(DEPTH)); // R6
endmodule

// File: rtl/rxadm_status.sv
module rxadm_status
  import rxadm_pkg::*;
#(
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] set_i,
  input  logic [NFLAGS-1:0] clr_i,
  input  logic [NFLAGS-1:0] en_i,
  input  logic              miss_inc_i,
  input  logic              miss_clr_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o,
  output logic [MISS_W-1:0] miss_o
);
  logic [NFLAGS-1:0] flags_q;
  logic [MISS_W-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      miss_q  <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_i;
      if (miss_clr_i)                   miss_q <= '0;
      else if (miss_inc_i && miss_q != '1) miss_q <= miss_q + MISS_W'(1);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);
  assign miss_o  = miss_q;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_q[g] && !clr_i[g] |=> flags_q[g]); // R10
  end
  AST_MISS_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q == '1 && !miss_clr_i |=> miss_q == '1); // R12
  AST_MISS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_clr_i |=> miss_q == '0); // R12
endmodule

// File: rtl/eth_rx_admit.sv
module eth_rx_admit
  import rxadm_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int MAX_FRAMES  = 24,
  parameter int RUNT_LEN    = 32,
  parameter int RESUME_FREE = 32,
  parameter int MISS_W      = 16,
  localparam int AW = $clog2(FIFO_DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  input  logic              byte_pop_i,
  output logic [7:0]        byte_data_o,
  output logic [PW-1:0]     byte_avail_o,
  input  logic              rec_pop_i,
  output logic              rec_valid_o,
  output logic [PW-1:0]     rec_len_o,
  output logic              rec_err_o,
  output logic              rec_trunc_o,
  input  logic              wb_done_i,
  input  logic [4:0]        flag_clr_i,
  input  logic [4:0]        irq_en_i,
  output logic [4:0]        flags_o,
  output logic              irq_o,
  input  logic              miss_clr_i,
  output logic [MISS_W-1:0] miss_cnt_o
);
  localparam int CW = $clog2(MAX_FRAMES + 1);
  localparam logic [PW-1:0] RUNT_W   = PW'(RUNT_LEN);
  localparam logic [PW-1:0] RESUME_W = PW'(RESUME_FREE);
  localparam logic [CW-1:0] MAXF_W   = CW'(MAX_FRAMES);

  adm_state_e    state_q, state_d;
  logic [PW-1:0] len_q, len_base, len_n, free;
  logic [CW-1:0] rec_cnt;
  logic          blocked_q, blk_eff;
  logic          start, space_ovf, cnt_ovf, take, cut, end_ok, flush, commit, wr_en;
  logic          wb_pend_q, wb_err_q, wb_trunc_q, rec_pop_eff;
  logic [NFLAGS-1:0] flag_set;

  // admission is decided on the first byte only
  assign start     = rx_valid_i && state_q == ST_IDLE;
  assign blk_eff   = blocked_q && free < RESUME_W;
  assign space_ovf = start && (blk_eff || free == '0);
  assign cnt_ovf   = start && !space_ovf && rec_cnt == MAXF_W;
  assign take      = rx_valid_i && (state_q == ST_TAKE || (start && !space_ovf && !cnt_ovf));
  assign len_base  = start ? '0 : len_q;
  assign len_n     = len_base + PW'(1);
  assign cut       = take && free == '0;
  assign end_ok    = take && !cut && rx_last_i;
  assign flush     = end_ok && rx_err_i && len_n < RUNT_W;
  assign commit    = (end_ok && !flush) || cut;
  assign wr_en     = take && !cut && !flush;

  always_comb begin
    state_d = state_q;
    if (space_ovf || cnt_ovf)            state_d = rx_last_i ? ST_IDLE : ST_DROP;
    else if (take)                       state_d = rx_last_i ? ST_IDLE : (cut ? ST_DROP : ST_TAKE);
    else if (state_q == ST_DROP && rx_valid_i && rx_last_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      len_q     <= '0;
      blocked_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take && !cut) len_q <= len_n;
      if (space_ovf || cut)                blocked_q <= 1'b1;
      else if (blocked_q && free >= RESUME_W) blocked_q <= 1'b0;
    end
  end

  assign rec_pop_eff = rec_pop_i && rec_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_pend_q  <= 1'b0;
      wb_err_q   <= 1'b0;
      wb_trunc_q <= 1'b0;
    end else if (rec_pop_eff) begin
      wb_pend_q  <= 1'b1;
      wb_err_q   <= rec_err_o;
      wb_trunc_q <= rec_trunc_o;
    end else if (wb_done_i) begin
      wb_pend_q  <= 1'b0;
    end
  end

  always_comb begin
    flag_set             = '0;
    flag_set[FL_FRERR]   = wb_done_i && wb_pend_q && wb_err_q;
    flag_set[FL_ABORT]   = wb_done_i && wb_pend_q && wb_err_q;
    flag_set[FL_CUTOFF]  = wb_done_i && wb_pend_q && wb_trunc_q;
    flag_set[FL_BYTEOVF] = space_ovf;
    flag_set[FL_CNTOVF]  = cnt_ovf;
  end

  rxadm_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_data_i(rx_data_i), .commit_i(commit), .flush_i(flush),
    .rd_en_i(byte_pop_i), .rd_data_o(byte_data_o), .free_o(free), .avail_o(byte_avail_o)
  );

  rxadm_rec_queue #(.DEPTH(MAX_FRAMES), .LW(PW)) u_recq (
    .clk_i, .rst_ni,
    .push_i(commit), .push_len_i(cut ? len_base : len_n),
    .push_err_i(!cut && rx_err_i), .push_trunc_i(cut),
    .pop_i(rec_pop_i), .valid_o(rec_valid_o), .len_o(rec_len_o),
    .err_o(rec_err_o), .trunc_o(rec_trunc_o), .cnt_o(rec_cnt)
  );

  rxadm_status #(.MISS_W(MISS_W)) u_stat (
    .clk_i, .rst_ni,
    .set_i(flag_set), .clr_i(flag_clr_i), .en_i(irq_en_i),
    .miss_inc_i(space_ovf || cnt_ovf), .miss_clr_i(miss_clr_i),
    .flags_o(flags_o), .irq_o(irq_o), .miss_o(miss_cnt_o)
  );

  AST_DROP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DROP && !(rx_valid_i && rx_last_i) |=> state_q == ST_DROP); // R9
  AST_WB_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_done_i && wb_pend_q && wb_err_q |=> flags_o[FL_FRERR] && flags_o[FL_ABORT]); // R4
  AST_OVF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    space_ovf || cnt_ovf |=> byte_avail_o <= $past(byte_avail_o)); // R5
endmodule

// File: tb/sim_eth_rx_admit.sv
module sim_eth_rx_admit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int MAXF  = 24;
  localparam int MW    = 4;
  localparam int PW    = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_last = 0, rx_err = 0, byte_pop = 0, rec_pop = 0, wb_done = 0, miss_clr = 0;
  logic [7:0] rx_data = 0;
  logic [4:0] flag_clr = 0, irq_en = 5'h1f;
  logic [7:0] byte_data;
  logic [PW-1:0] byte_avail, rec_len;
  logic rec_valid, rec_err, rec_trunc, irq;
  logic [4:0] flags;
  logic [MW-1:0] miss_cnt;

  int vectors = 0, fails = 0;
  logic [7:0] seed = 8'h10;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_admit #(.FIFO_DEPTH(DEPTH), .MAX_FRAMES(MAXF), .MISS_W(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_err_i(rx_err),
    .byte_pop_i(byte_pop), .byte_data_o(byte_data), .byte_avail_o(byte_avail),
    .rec_pop_i(rec_pop), .rec_valid_o(rec_valid), .rec_len_o(rec_len),
    .rec_err_o(rec_err), .rec_trunc_o(rec_trunc), .wb_done_i(wb_done),
    .flag_clr_i(flag_clr), .irq_en_i(irq_en), .flags_o(flags), .irq_o(irq),
    .miss_clr_i(miss_clr), .miss_cnt_o(miss_cnt)
  );

  // behavioural reference model
  typedef struct { int len; bit err; bit tr; } rec_t;
  logic [7:0] cq[$], tq[$];
  rec_t rq[$];
  int   mstate, mmiss, m_free, m_nrec;
  bit   mblk, wbp, wbe, wbt, m_start, m_sovf, m_covf, m_cut, m_clr_blk;
  bit [4:0] mflags, m_set;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq.delete(); tq.delete(); rq.delete();
      mstate = 0; mmiss = 0; mblk = 0; wbp = 0; wbe = 0; wbt = 0; mflags = 0;
    end else begin
      m_free = DEPTH - cq.size() - tq.size();
      m_nrec = rq.size();
      m_set = 0; m_cut = 0;
      m_clr_blk = mblk && m_free >= 32;
      m_start = rx_valid && mstate == 0;
      m_sovf = m_start && ((mblk && m_free < 32) || m_free == 0);
      m_covf = m_start && !m_sovf && m_nrec == MAXF;
      if (wb_done && wbp) begin
        if (wbe) m_set |= 5'h03;
        if (wbt) m_set |= 5'h10;
      end
      if (rec_pop && m_nrec > 0) begin
        wbp = 1; wbe = rq[0].err; wbt = rq[0].tr; void'(rq.pop_front());
      end else if (wb_done) wbp = 0;
      if (byte_pop && cq.size() > 0) void'(cq.pop_front());
      if (m_sovf || m_covf) begin
        m_set |= m_sovf ? 5'h04 : 5'h08;
        mstate = rx_last ? 0 : 2;
      end else if (rx_valid && (mstate == 1 || m_start)) begin
        if (m_start) tq.delete();
        if (m_free == 0) begin
          m_cut = 1;
          rq.push_back('{tq.size(), 1'b0, 1'b1});
          foreach (tq[i]) cq.push_back(tq[i]);
          tq.delete();
          mstate = rx_last ? 0 : 2;
        end else begin
          tq.push_back(rx_data);
          if (rx_last) begin
            if (!(rx_err && tq.size() < 32)) begin
              rq.push_back('{tq.size(), rx_err, 1'b0});
              foreach (tq[i]) cq.push_back(tq[i]);
            end
            tq.delete();
            mstate = 0;
          end else mstate = 1;
        end
      end else if (mstate == 2 && rx_valid && rx_last) mstate = 0;
      if (m_sovf || m_cut) mblk = 1;
      else if (m_clr_blk) mblk = 0;
      mflags = (mflags & ~flag_clr) | m_set;
      if (miss_clr) mmiss = 0;
      else if ((m_sovf || m_covf) && mmiss < (1 << MW) - 1) mmiss++;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1 avail", byte_avail, cq.size());
      if (cq.size() > 0) chk("R1 data", byte_data, cq[0]);
      chk("R2 rec_valid", rec_valid, rq.size() > 0);
      if (rq.size() > 0) begin
        chk("R2 rec_len", rec_len, rq[0].len);
        chk("R4 rec_err", rec_err, rq[0].err);
        chk("R7 rec_trunc", rec_trunc, rq[0].tr);
      end
      chk("R4 flag frerr", flags[0], mflags[0]);
      chk("R4 flag abort", flags[1], mflags[1]);
      chk("R5 flag byteovf", flags[2], mflags[2]);
      chk("R6 flag cntovf", flags[3], mflags[3]);
      chk("R7 flag cutoff", flags[4], mflags[4]);
      chk("R11 irq", irq, |(mflags & irq_en));
      chk("R12 miss", miss_cnt, mmiss);
    end
  end

  task automatic send(int len, bit err);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_data = seed; seed = seed + 8'd1;
      rx_last = (i == len - 1); rx_err = err && (i == len - 1);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0; rx_err = 0;
    @(negedge clk);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      byte_pop = 1; @(negedge clk);
    end
    byte_pop = 0;
  endtask

  task automatic pop_wb();
    rec_pop = 1; @(negedge clk);
    rec_pop = 0; wb_done = 1; @(negedge clk);
    wb_done = 0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  int mb;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset avail", byte_avail, 0);
    chk("R10 reset flags", flags, 0);
    rst_n = 1;
    @(negedge clk);
    // normal frames
    send(40, 0); send(5, 0);
    chk("R1 two frames avail", byte_avail, 45);
    drain(45); pop_wb(); pop_wb();
    // runt boundary
    send(10, 1); send(31, 1);
    chk("R3 runt no bytes", byte_avail, 0);
    chk("R3 runt no record", rec_valid, 0);
    send(32, 1);
    chk("R3 32-byte error frame kept", rec_len, 32);
    drain(32); pop_wb();
    chk("R4 flags after write-back", flags & 5'h03, 3);
    flag_clr = 5'h03; @(negedge clk); flag_clr = 0; @(negedge clk);
    chk("R10 cleared", flags, 0);
    // cut-off, byte overflow, resume hold
    send(40, 0); send(40, 0);
    chk("R7 miss unchanged on cut-off", miss_cnt, 0);
    send(8, 0);
    chk("R5 byte overflow miss", miss_cnt, 1);
    drain(20);
    mb = miss_cnt;
    send(8, 0);
    chk("R8 refused below resume space", miss_cnt, mb + 1);
    drain(20);
    send(8, 0);
    chk("R8 accepted after resume", byte_avail, 32);
    drain(32); pop_wb(); pop_wb(); pop_wb();
    chk("R7 cutoff flag", flags[4], 1);
    // refused frame stays dropped while space frees
    send(64, 0);
    fork
      send(20, 0);
      drain(64);
    join
    chk("R9 no bytes from refused frame", byte_avail, 0);
    pop_wb();
    chk("R9 no record from refused frame", rec_valid, 0);
    // frame-count overflow
    for (int k = 0; k < 24; k++) send(1, 0);
    mb = miss_cnt;
    send(1, 0);
    chk("R6 count overflow flag", flags[3], 1);
    chk("R6 count overflow miss", miss_cnt, mb + 1);
    drain(1); pop_wb();
    send(1, 0);
    chk("R6 accepted after pop", byte_avail, 24);
    for (int k = 0; k < 20; k++) send(1, 0);
    chk("R12 saturated", miss_cnt, 15);
    miss_clr = 1; @(negedge clk); miss_clr = 0; @(negedge clk);
    chk("R12 cleared", miss_cnt, 0);
    // interrupt masking
    irq_en = 0; @(negedge clk);
    chk("R11 masked", irq, 0);
    irq_en = 5'h08; @(negedge clk);
    chk("R11 enabled count flag", irq, 1);
    flag_clr = 5'h1f; @(negedge clk); flag_clr = 0; @(negedge clk);
    chk("R10 all cleared", flags, 0);
    drain(24);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule